// File: doc/BRIEF.md
# Three-Level Interrupt Summary Controller

This block gathers a large set of peripheral interrupt lines into one summary interrupt for a host processor. Each line has a private trigger setting and a sticky pending bit. Lines are arranged eight to a group and eight groups to a cluster. A top-level summary register, one register per cluster and one pending register per group let software find an active line in three reads. Software first reads the top summary to find a cluster. It then reads that cluster's register to find a group. Last, it selects the group and reads the group's pending byte.

All per-line state is reached through a small window on an 8-bit register bus with a 16-bit address. Software writes a group number into a selector register. The pending, live-level and trigger-setting registers then act on that group. A trigger-setting write carries a commit flag, a 3-bit line index inside the group, a clear request, two edge masks and a level/edge choice.

The lines are asynchronous. Each passes through a two-stage synchronizer before any edge or level test. The summary output is registered.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset every line has both edge masks set and level select 0, all pending bits are 0, the group selector is 0 and irq_o is 0.
- R2: Registers sit at BASE (default 0x01BB) plus an offset. The offsets are: 0 top summary, 1..4 cluster 0..3 summary, 5 group selector, 6 pending byte of the selected group, 7 trigger setting (writes only, reads as 0) and 8 live levels of the selected group. Any other address reads 0, and writes to it have no effect. bus_rdata is 0 whenever bus_rd is low.
- R3: In the top summary, bit i+1 is set exactly when cluster i has any bit set. Bit 0 and bits 7:5 read 0.
- R4: Bit k of cluster m's register is 1 exactly when group 8m+k holds a pending line whose edge masks are not both set.
- R5: The pending byte read shows, at bit i, the sticky pending bit of line 8g+i, where g is the selector value. The selector holds wdata[4:0] and reads back in bits 4:0.
- R6: The live-level read shows, at bit i, the synchronized level of line 8g+i, whether or not that line is pending or masked.
- R7: The trigger-setting write uses bit 7 = commit, bits 6:4 = line index, bit 3 = clear, bit 2 = rising mask, bit 1 = falling mask and bit 0 = level select. A write with bit 7 = 0 changes nothing. A committed write replaces bits 2:0 of the indexed line.
- R8: With level select 0, a synchronized rising edge sets the pending bit if the rising mask is 0. A falling edge sets it if the falling mask is 0. With both masks set, the line never becomes pending.
- R9: With level select 1, the line becomes pending on every clock on which it is high and the rising mask is 0, or it is low and the falling mask is 0.
- R10: A pending bit stays set until a committed write with clear = 1 addresses its line. That clear wins in its own cycle. A level condition that still holds sets the bit again on the next clock.
- R11: A line change reaches its pending bit on the third clock edge after the change. irq_o is the registered OR of all cluster bits, one clock after the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 256 | Asynchronous interrupt lines |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational while bus_rd is high |
| irq_o | output | 1 | Summary interrupt |

## Verification
The assertions rely on two things. First, the bus never asserts a read and a write in the same cycle. Second, each write strobe lasts exactly one clock. The bench drives every bus strobe and line change on the falling clock edge and releases the strobes one cycle later, so both conditions always hold. The line inputs are treated as asynchronous. The bench still changes them only between edges, so the synchronizer latency is exactly two clocks and the model can count it.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;
  localparam int LINES_PER_GRP = 8;
  localparam int GRPS_PER_CLU  = 8;

  typedef struct packed {
    logic       clr;
    logic       mask_rise;
    logic       mask_fall;
    logic       lvl_sel;
  } trig_cmd_t;

  function automatic logic line_hit(input logic lvl_sel, input logic mask_rise,
                                    input logic mask_fall, input logic now_v,
                                    input logic was_v);
    logic r;
    if (lvl_sel)
      r = (!mask_rise && now_v) || (!mask_fall && !now_v);
    else
      r = (!mask_rise && now_v && !was_v) || (!mask_fall && !now_v && was_v);
    return r;
  endfunction

  function automatic logic line_enabled(input logic mask_rise, input logic mask_fall);
    return !(mask_rise && mask_fall);
  endfunction
endpackage

// File: rtl/irq_tree_sync.sv
module irq_tree_sync #(
  parameter int WIDTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] now_o,
  output logic [WIDTH-1:0] was_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] now_q;
  logic [WIDTH-1:0] was_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      now_q  <= '0;
      was_q  <= '0;
    end else begin
      meta_q <= async_i;
      now_q  <= meta_q;
      was_q  <= now_q;
    end
  end

  assign now_o = now_q;
  assign was_o = was_q;
endmodule

// File: rtl/irq_tree_cell.sv
module irq_tree_cell
  import irq_tree_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      now_i,
  input  logic      was_i,
  input  logic      wr_i,
  input  trig_cmd_t cmd_i,
  output logic      pend_o,
  output logic      en_o
);
  logic mask_rise_q, mask_fall_q, lvl_sel_q, pend_q;
  logic hit_w;
  logic clr_w;

  assign hit_w = line_hit(lvl_sel_q, mask_rise_q, mask_fall_q, now_i, was_i);
  assign clr_w = wr_i && cmd_i.clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_rise_q <= 1'b1;
      mask_fall_q <= 1'b1;
      lvl_sel_q   <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      if (wr_i) begin
        mask_rise_q <= cmd_i.mask_rise;
        mask_fall_q <= cmd_i.mask_fall;
        lvl_sel_q   <= cmd_i.lvl_sel;
      end
      if (clr_w)      pend_q <= 1'b0;
      else if (hit_w) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = line_enabled(mask_rise_q, mask_fall_q);

  p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && cmd_i.clr) |=> !pend_o);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !(wr_i && cmd_i.clr)) |=> pend_o);
  p_off_stays_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o && !en_o) |=> !pend_o);
endmodule

// File: rtl/irq_tree_regs.sv
module irq_tree_regs
  import irq_tree_pkg::*;
#(
  parameter int          N_LINES = 256,
  parameter logic [15:0] BASE    = 16'h01BB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [N_LINES-1:0] pend_i,
  input  logic [N_LINES-1:0] now_i,
  input  logic [N_LINES/(LINES_PER_GRP*GRPS_PER_CLU)-1:0][GRPS_PER_CLU-1:0] clu_i,
  output logic [N_LINES-1:0] cell_wr_o,
  output trig_cmd_t          cmd_o,
  output logic [7:0]         bus_rdata
);
  localparam int N_GRP  = N_LINES / LINES_PER_GRP;
  localparam int N_CLU  = N_GRP / GRPS_PER_CLU;
  localparam int SEL_W  = $clog2(N_GRP);
  localparam int IDX_W  = $clog2(LINES_PER_GRP);

  logic [SEL_W-1:0] sel_q;
  logic [15:0]      off_w;
  logic             in_win_w;
  logic             cfg_commit_w;
  logic [7:0]       rd_w;
  logic [N_CLU-1:0] clu_any_w;

  assign off_w        = bus_addr - BASE;
  assign in_win_w     = (bus_addr >= BASE) && (off_w <= 16'd8) && (bus_addr <= 16'h03FF);
  assign cfg_commit_w = bus_wr && in_win_w && (off_w == 16'd7) && bus_wdata[7];
  assign cmd_o        = trig_cmd_t'(bus_wdata[3:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (bus_wr && in_win_w && (off_w == 16'd5)) sel_q <= bus_wdata[SEL_W-1:0];
  end

  always_comb begin
    cell_wr_o = '0;
    if (cfg_commit_w)
      cell_wr_o[{sel_q, bus_wdata[4+IDX_W-1:4]}] = 1'b1;
  end

  genvar m;
  generate
    for (m = 0; m < N_CLU; m++) begin : g_any
      assign clu_any_w[m] = |clu_i[m];
    end
  endgenerate

  always_comb begin
    rd_w = '0;
    if (in_win_w) begin
      if (off_w == 16'd0)
        rd_w[N_CLU:1] = clu_any_w;
      else if (off_w >= 16'd1 && off_w <= 16'(N_CLU))
        rd_w = clu_i[off_w[SEL_W-1:0] - 1'b1];
      else if (off_w == 16'd5)
        rd_w[SEL_W-1:0] = sel_q;
      else if (off_w == 16'd6)
        rd_w = pend_i[sel_q*LINES_PER_GRP +: LINES_PER_GRP];
      else if (off_w == 16'd8)
        rd_w = now_i[sel_q*LINES_PER_GRP +: LINES_PER_GRP];
    end
  end

  assign bus_rdata = bus_rd ? rd_w : 8'h00;

  p_root_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == BASE) |-> (bus_rdata[0] == 1'b0));
  p_commit_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|cell_wr_o) |-> (bus_wr && bus_wdata[7]));
  p_one_cell_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_wr_o));
  p_idle_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 8'h00));
endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int          N_LINES = 256,
  parameter logic [15:0] BASE    = 16'h01BB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] src_i,
  input  logic [15:0]        bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  output logic [7:0]         bus_rdata,
  output logic               irq_o
);
  localparam int N_GRP = N_LINES / LINES_PER_GRP;
  localparam int N_CLU = N_GRP / GRPS_PER_CLU;

  logic [N_LINES-1:0] now_w, was_w, pend_w, en_w, cell_wr_w;
  logic [N_CLU-1:0][GRPS_PER_CLU-1:0] clu_w;
  trig_cmd_t cmd_w;
  logic irq_q;

  irq_tree_sync #(.WIDTH(N_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(src_i), .now_o(now_w), .was_o(was_w));

  genvar n, g;
  generate
    for (n = 0; n < N_LINES; n++) begin : g_cell
      irq_tree_cell u_cell (
        .clk(clk), .rst_n(rst_n), .now_i(now_w[n]), .was_i(was_w[n]),
        .wr_i(cell_wr_w[n]), .cmd_i(cmd_w), .pend_o(pend_w[n]), .en_o(en_w[n]));
    end
    for (g = 0; g < N_GRP; g++) begin : g_grp
      assign clu_w[g / GRPS_PER_CLU][g % GRPS_PER_CLU] =
        |(pend_w[g*LINES_PER_GRP +: LINES_PER_GRP] & en_w[g*LINES_PER_GRP +: LINES_PER_GRP]);
    end
  endgenerate

  irq_tree_regs #(.N_LINES(N_LINES), .BASE(BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .pend_i(pend_w), .now_i(now_w),
    .clu_i(clu_w), .cell_wr_o(cell_wr_w), .cmd_o(cmd_w), .bus_rdata(bus_rdata));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |clu_w;
  end
  assign irq_o = irq_q;

  p_irq_has_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(pend_w & en_w)));
  p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_w & en_w)) |=> irq_o);
endmodule

// File: tb/irq_tree_ctrl_tb_top.sv
module irq_tree_ctrl_tb_top;
  localparam int N = 256;
  localparam logic [15:0] BASE = 16'h01BB;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic [15:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic wr = 0, rd = 0, irq;
  int errors = 0, checks = 0, cyc = 0;

  irq_tree_ctrl dut_i (.clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
    .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd), .bus_rdata(rdata), .irq_o(irq));

  always #2 clk = ~clk;

  // behavioural reference state
  logic [N-1:0] m_s1, m_s2, m_prev, m_lat, m_mr, m_mf, m_lv;
  logic [4:0] m_sel;
  logic m_irq;

  function automatic logic en_of(int n);
    return !(m_mr[n] && m_mf[n]);
  endfunction

  function automatic logic grp_active(int b);
    logic a = 0;
    for (int i = 0; i < 8; i++) if (m_lat[b*8+i] && en_of(b*8+i)) a = 1;
    return a;
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a);
    logic [7:0] r = 0;
    int off;
    if (a < BASE || a > BASE + 16'd8) return 8'h00;
    off = int'(a - BASE);
    case (off)
      0: for (int m = 0; m < 4; m++)
           for (int k = 0; k < 8; k++) if (grp_active(m*8+k)) r[m+1] = 1;
      1, 2, 3, 4: for (int k = 0; k < 8; k++) r[k] = grp_active((off-1)*8+k);
      5: r = {3'b000, m_sel};
      6: for (int i = 0; i < 8; i++) r[i] = m_lat[m_sel*8+i];
      8: for (int i = 0; i < 8; i++) r[i] = m_s2[m_sel*8+i];
      default: r = 0;
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] nlat;
    logic any;
    cyc++;
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_lat = '0;
      m_mr = '1; m_mf = '1; m_lv = '0; m_sel = 0; m_irq = 0;
    end else begin
      any = 0;
      for (int n = 0; n < N; n++) if (m_lat[n] && en_of(n)) any = 1;
      nlat = m_lat;
      for (int n = 0; n < N; n++) begin
        logic h;
        if (m_lv[n]) h = (!m_mr[n] && m_s2[n]) || (!m_mf[n] && !m_s2[n]);
        else h = (!m_mr[n] && m_s2[n] && !m_prev[n]) || (!m_mf[n] && !m_s2[n] && m_prev[n]);
        if (h) nlat[n] = 1;
      end
      if (wr && addr == BASE + 16'd7 && wdata[7]) begin
        int t;
        t = m_sel*8 + wdata[6:4];
        if (wdata[3]) nlat[t] = 0;
        m_mr[t] = wdata[2]; m_mf[t] = wdata[1]; m_lv[t] = wdata[0];
      end
      if (wr && addr == BASE + 16'd5) m_sel = wdata[4:0];
      m_lat = nlat; m_prev = m_s2; m_s2 = m_s1; m_s1 = src; m_irq = any;
    end
  end

  // R11: summary output compared on every cycle
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL R11 irq_o cyc=%0d actual=%b expected=%b", cyc, irq, m_irq);
    end
  end

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic check_read(input logic [15:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk); addr = a; rd = 1;
    #1; e = exp_read(a); checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s read addr=%h actual=%h expected=%h", tag, a, rdata, e);
    end
    @(negedge clk); rd = 0;
  endtask

  task automatic set_trig(input int line, input logic [3:0] bits);
    bus_write(BASE + 16'd5, 8'(line / 8));
    bus_write(BASE + 16'd7, {1'b1, 3'(line % 8), bits});
  endtask

  task automatic scan(input int line, input string tag);
    check_read(BASE, tag);
    check_read(BASE + 16'(1 + line/64), tag);
    bus_write(BASE + 16'd5, 8'(line / 8));
    check_read(BASE + 16'd6, tag);
    check_read(BASE + 16'd8, tag);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1, R2: reset state over every offset and outside the window
        for (int o = 0; o <= 9; o++) check_read(BASE + 16'(o), "R1");
        check_read(BASE - 16'd1, "R2");
        // R2: idle read strobe low
        @(negedge clk); addr = BASE + 16'd5; #1; checks++;
        if (rdata !== 8'h00) begin errors++; $display("FAIL R2 idle actual=%h expected=00", rdata); end
        // R5: selector round trip and truncation
        bus_write(BASE + 16'd5, 8'hFF);
        check_read(BASE + 16'd5, "R5");
        bus_write(BASE + 16'd5, 8'h00);
        // R8: rising-edge line 0
        set_trig(0, 4'b1010);
        src[0] = 1; idle(1); check_read(BASE + 16'd6, "R11"); idle(4);
        scan(0, "R8");
        // R3/R4: falling edge on line 9, both edges on 77
        set_trig(9, 4'b1100);
        set_trig(77, 4'b1000);
        src[9] = 1; src[77] = 1; idle(6); scan(77, "R4");
        src[9] = 0; src[77] = 0; idle(6); scan(9, "R3"); scan(77, "R3");
        // R8: both masked line 40 never pends
        src[40] = 1; idle(6); src[40] = 0; idle(6); scan(40, "R8");
        // R6: live level independent of mask
        src[41] = 1; idle(4); scan(41, "R6"); src[41] = 0;
        // R7: uncommitted write ignored
        bus_write(BASE + 16'd5, 8'd0);
        bus_write(BASE + 16'd7, 8'h08);
        check_read(BASE + 16'd6, "R7");
        // R10: clear of line 0
        bus_write(BASE + 16'd7, 8'h8E);
        check_read(BASE + 16'd6, "R10");
        // R9: active-high level on 130, active-low on 255
        set_trig(130, 4'b1011);
        set_trig(255, 4'b1101);
        idle(4); scan(255, "R9"); scan(130, "R9");
        src[130] = 1; src[255] = 1; idle(5); scan(130, "R9");
        // R10: clear while level held re-latches
        bus_write(BASE + 16'd7, {1'b1, 3'd2, 4'b1011});
        check_read(BASE + 16'd6, "R10");
        idle(2); check_read(BASE + 16'd6, "R10");
        src[130] = 0;
        bus_write(BASE + 16'd7, {1'b1, 3'd2, 4'b1011});
        idle(4); check_read(BASE + 16'd6, "R10");
        // mixed pattern: random lines, configs and reads
        begin
          logic [31:0] x = 32'h1234_5678;
          for (int it = 0; it < 600; it++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            src[x[7:0]] = ~src[x[7:0]];
            if (x[31:29] == 0) set_trig(int'(x[15:8]), x[19:16]);
            else if (x[31:29] == 1) check_read(BASE + 16'(x[24:21] % 9), "R4");
            else idle(1);
          end
        end
        for (int o = 0; o <= 8; o++) check_read(BASE + 16'(o), "R3");
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule